// File: doc/BRIEF.md
# Two-Port Collision Busy Arbiter

This block sits in front of a memory array that two independent ports share, called left and right here. Each clock cycle it compares the two ports' selects and addresses. When both ports select the same word, that word is a collision. The block gives the word to one port and raises a busy flag towards the other. It also hands the array a write strobe for each port, and it suppresses the strobe of a port that has lost the word. The array itself is not part of the block. The array uses the strobes the block produces, not the raw write requests.

A mode input picks where busy comes from. In master mode the block runs its own arbitration. In slave mode the internal arbitration has no effect: busy and write suppression follow an external busy input per port. That input is fed from the master's busy outputs, so several of these blocks can be stacked side by side to make a wider word. A port keeps a word it has won for as long as it stays on that word. If both ports arrive at the same word in the same cycle, the left port wins.

Top module: `dp_busy_arbiter`

## Requirements
- R1: In master mode, a collision exists only when both selects are high and the two addresses are equal. Without one, neither busy output is raised and no write strobe is suppressed.
- R2: In master mode, exactly one of `busy_l_o` / `busy_r_o` is high in the cycle after a collision cycle. The two are never high together.
- R3: When both ports begin a collision in the same cycle (neither was on that word with its select high in the previous cycle), the left port wins and `busy_r_o` rises.
- R4: A collision starts either when a port changes its address onto the word that the other port already holds, or when a port's select rises while the addresses already match. In either case the port that arrived later gets busy.
- R5: The winning port keeps the word for as long as its select stays high and its address is unchanged, whatever the other port does. Each port's previous select and address are remembered for one cycle for this purpose.
- R6: Busy outputs are active high and registered. Each rises one cycle after the cycle in which its port loses, and falls one cycle after the collision ends.
- R7: In master mode, `wr_l_o` (or `wr_r_o`) equals select AND write request of that port, except in a cycle in which that port loses the arbitration. In that cycle the strobe is 0.
- R8: In slave mode, a port's write strobe is 0 in any cycle in which its `busy_ext` input is high, and internal arbitration has no effect on the strobes.
- R9: In slave mode, each busy output equals its `busy_ext` input delayed by one cycle.
- R10: While `rst_n` is low, both busy outputs are 0 and the held owner is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | 1 = arbitrate internally, 0 = follow external busy |
| cs_l_i | input | 1 | Left port select, active high |
| addr_l_i | input | AW | Left port word address |
| we_l_i | input | 1 | Left port write request |
| cs_r_i | input | 1 | Right port select, active high |
| addr_r_i | input | AW | Right port word address |
| we_r_i | input | 1 | Right port write request |
| busy_ext_l_i | input | 1 | External busy for the left port (slave mode) |
| busy_ext_r_i | input | 1 | External busy for the right port (slave mode) |
| busy_l_o | output | 1 | Registered busy towards the left port |
| busy_r_o | output | 1 | Registered busy towards the right port |
| wr_l_o | output | 1 | Gated left write strobe to the array |
| wr_r_o | output | 1 | Gated right write strobe to the array |

## Verification
The write strobes are combinational and are due in the same cycle as the inputs. The bench drives inputs on the falling edge and compares the strobes one time step later, before the rising edge. The busy outputs become valid at the rising edge after their cause, so the bench compares them at the following falling edge, before it drives anything new. The bench tracks previous selects, addresses and the held owner in integers, and advances that state only at the rising edge. Each check therefore compares against exactly the cycle the RTL registers would see. A behavioural memory written through the DUT strobes is compared against one written through the expected strobes.

// File: rtl/dpb_pkg.sv
package dpb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  localparam int NPORT = 2;
  localparam int PL    = 0;
  localparam int PR    = 1;
endpackage

// File: rtl/dpb_match.sv
module dpb_match #(
  parameter int AW = 10
) (
  input  logic          cs_l,
  input  logic          cs_r,
  input  logic [AW-1:0] addr_l,
  input  logic [AW-1:0] addr_r,
  output logic          hit
);
  always_comb begin
    hit = cs_l & cs_r & (addr_l == addr_r);
  end
endmodule

// File: rtl/dpb_track.sv
// Remembers a port's select and address from the previous cycle and
// reports whether the port is still on the same word.
module dpb_track #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic [AW-1:0] addr,
  output logic          kept
);
  logic          cs_q,   cs_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          upd_en;

  always_comb begin
    upd_en = 1'b1;
    cs_d   = cs;
    addr_d = cs ? addr : addr_q;
    kept   = cs & cs_q & (addr == addr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b0;
      addr_q <= '0;
    end else if (upd_en) begin
      cs_q   <= cs_d;
      addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/dpb_arb.sv
module dpb_arb
  import dpb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [NPORT-1:0] kept,
  output logic [NPORT-1:0] lose
);
  owner_e owner_q, owner_d;

  always_comb begin
    if (!hit)                                   owner_d = OWN_NONE;
    else if (owner_q == OWN_LEFT  && kept[PL])  owner_d = OWN_LEFT;
    else if (owner_q == OWN_RIGHT && kept[PR])  owner_d = OWN_RIGHT;
    else if (kept[PR] && !kept[PL])             owner_d = OWN_RIGHT;
    else                                        owner_d = OWN_LEFT;
    lose[PL] = (owner_d == OWN_RIGHT);
    lose[PR] = (owner_d == OWN_LEFT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else        owner_q <= owner_d;
  end

  assert_loss_needs_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lose[PL] | lose[PR]) |-> hit);

  assert_hold_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_LEFT && hit && kept[PL]) |-> (lose[PR] && !lose[PL]));

  assert_hold_right_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_RIGHT && hit && kept[PR]) |-> (lose[PL] && !lose[PR]));

  assert_fresh_tie_left_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !kept[PL] && !kept[PR]) |-> lose[PR]);
endmodule

// File: rtl/dpb_gate.sv
// Per-port write suppression and registered busy.
module dpb_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic master,
  input  logic lose_int,
  input  logic busy_ext,
  input  logic cs,
  input  logic we,
  output logic wr,
  output logic busy
);
  logic lose_sel;
  logic busy_d;

  always_comb begin
    lose_sel = master ? lose_int : busy_ext;
    wr       = cs & we & ~lose_sel;
    busy_d   = lose_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= 1'b0;
    else        busy <= busy_d;
  end

  assert_slave_blocks_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && busy_ext) |-> !wr);
endmodule

// File: rtl/dp_busy_arbiter.sv
module dp_busy_arbiter
  import dpb_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_i,
  input  logic          cs_l_i,
  input  logic [AW-1:0] addr_l_i,
  input  logic          we_l_i,
  input  logic          cs_r_i,
  input  logic [AW-1:0] addr_r_i,
  input  logic          we_r_i,
  input  logic          busy_ext_l_i,
  input  logic          busy_ext_r_i,
  output logic          busy_l_o,
  output logic          busy_r_o,
  output logic          wr_l_o,
  output logic          wr_r_o
);
  logic                     hit;
  logic [NPORT-1:0]         kept, lose, cs_v, we_v, bx_v, wr_v, busy_v;
  logic [NPORT-1:0][AW-1:0] addr_v;

  assign cs_v   = {cs_r_i, cs_l_i};
  assign we_v   = {we_r_i, we_l_i};
  assign bx_v   = {busy_ext_r_i, busy_ext_l_i};
  assign addr_v = {addr_r_i, addr_l_i};

  dpb_match #(.AW(AW)) u_match (
    .cs_l(cs_l_i), .cs_r(cs_r_i), .addr_l(addr_l_i), .addr_r(addr_r_i), .hit(hit)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpb_track #(.AW(AW)) u_track (
      .clk(clk), .rst_n(rst_n), .cs(cs_v[p]), .addr(addr_v[p]), .kept(kept[p])
    );
    dpb_gate u_gate (
      .clk(clk), .rst_n(rst_n), .master(master_i), .lose_int(lose[p]),
      .busy_ext(bx_v[p]), .cs(cs_v[p]), .we(we_v[p]), .wr(wr_v[p]), .busy(busy_v[p])
    );
  end

  dpb_arb u_arb (
    .clk(clk), .rst_n(rst_n), .hit(hit), .kept(kept), .lose(lose)
  );

  assign busy_l_o = busy_v[PL];
  assign busy_r_o = busy_v[PR];
  assign wr_l_o   = wr_v[PL];
  assign wr_r_o   = wr_v[PR];

  assert_busy_mutex_R2: assert property (@(posedge clk) disable iff (!rst_n)
    master_i |=> !(busy_l_o && busy_r_o));

  assert_busy_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (master_i && !hit) |=> (!busy_l_o && !busy_r_o));

  assert_loser_write_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (master_i && hit) |-> !(wr_l_o && wr_r_o));
endmodule

// File: tb/sim_dp_busy_arbiter.sv
module sim_dp_busy_arbiter;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic master_i, cs_l_i, we_l_i, cs_r_i, we_r_i, busy_ext_l_i, busy_ext_r_i;
  logic [AW-1:0] addr_l_i, addr_r_i;
  logic busy_l_o, busy_r_o, wr_l_o, wr_r_o;

  always #5 clk = ~clk;

  dp_busy_arbiter #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .master_i(master_i),
    .cs_l_i(cs_l_i), .addr_l_i(addr_l_i), .we_l_i(we_l_i),
    .cs_r_i(cs_r_i), .addr_r_i(addr_r_i), .we_r_i(we_r_i),
    .busy_ext_l_i(busy_ext_l_i), .busy_ext_r_i(busy_ext_r_i),
    .busy_l_o(busy_l_o), .busy_r_o(busy_r_o), .wr_l_o(wr_l_o), .wr_r_o(wr_r_o)
  );

  int vectors = 0, errors = 0, cyc = 0;
  // reference state: owner 0 none, 1 left, 2 right
  int owner = 0;
  bit pcsl = 0, pcsr = 0;
  int pal = 0, par = 0;
  bit eb_l = 0, eb_r = 0;
  int mem_dut[16];
  int mem_ref[16];

  task automatic cmp(input string tag, input string what, input bit act, input bit exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d: actual %0b expected %0b", tag, what, cyc, act, exp);
    end
  endtask

  task automatic tick(input string tag, input bit m,
                      input bit csl, input int al, input bit wel,
                      input bit csr, input int ar, input bit wer,
                      input bit bxl, input bit bxr);
    int  win;
    bit  match, lk, rk, ll, lr, xl, xr;
    @(negedge clk);
    cmp(tag, "busy_l_o", busy_l_o, eb_l);
    cmp(tag, "busy_r_o", busy_r_o, eb_r);
    master_i = m; cs_l_i = csl; addr_l_i = AW'(al); we_l_i = wel;
    cs_r_i = csr; addr_r_i = AW'(ar); we_r_i = wer;
    busy_ext_l_i = bxl; busy_ext_r_i = bxr;
    #1;
    match = csl && csr && (al == ar);
    lk = pcsl && csl && (al == pal);
    rk = pcsr && csr && (ar == par);
    if (!match)                 win = 0;
    else if (owner == 1 && lk)  win = 1;
    else if (owner == 2 && rk)  win = 2;
    else if (rk && !lk)         win = 2;
    else                        win = 1;
    ll = m ? (win == 2) : bxl;
    lr = m ? (win == 1) : bxr;
    xl = csl && wel && !ll;
    xr = csr && wer && !lr;
    cmp(tag, "wr_l_o", wr_l_o, xl);
    cmp(tag, "wr_r_o", wr_r_o, xr);
    @(posedge clk);
    if (wr_l_o) mem_dut[al] = 100 + cyc;
    if (wr_r_o) mem_dut[ar] = 200 + cyc;
    if (xl) mem_ref[al] = 100 + cyc;
    if (xr) mem_ref[ar] = 200 + cyc;
    eb_l = ll; eb_r = lr; owner = win;
    pcsl = csl; pcsr = csr;
    if (csl) pal = al;
    if (csr) par = ar;
    cyc++;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin mem_dut[i] = 0; mem_ref[i] = 0; end
    rst_n = 1'b0;
    master_i = 1; cs_l_i = 0; cs_r_i = 0; we_l_i = 0; we_r_i = 0;
    addr_l_i = '0; addr_r_i = '0; busy_ext_l_i = 0; busy_ext_r_i = 0;
    // R10: busy low during reset even with a collision on the pins
    repeat (2) @(negedge clk);
    cs_l_i = 1; cs_r_i = 1;
    @(negedge clk);
    cmp("R10", "busy_l_o", busy_l_o, 1'b0);
    cmp("R10", "busy_r_o", busy_r_o, 1'b0);
    cs_l_i = 0; cs_r_i = 0;
    @(negedge clk);
    rst_n = 1'b1;

    // R1: enabled but different addresses, or same address with one select low
    tick("R1", 1, 1, 3, 1, 1, 4, 1, 0, 0);
    tick("R1", 1, 1, 5, 1, 0, 5, 1, 0, 0);
    tick("R1", 1, 0, 6, 1, 1, 6, 1, 0, 0);
    tick("R1", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R3: fresh tie in one cycle, left wins; R7 right write suppressed
    tick("R3", 1, 1, 7, 1, 1, 7, 1, 0, 0);
    tick("R2", 1, 1, 7, 0, 1, 7, 1, 0, 0);
    // R6: collision ends, busy falls one cycle later
    tick("R6", 1, 0, 7, 0, 1, 7, 1, 0, 0);
    tick("R6", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R4: right holds word 9, left moves onto it by address change
    tick("R4", 1, 1, 2, 0, 1, 9, 1, 0, 0);
    tick("R4", 1, 1, 9, 1, 1, 9, 1, 0, 0);
    tick("R5", 1, 1, 9, 1, 1, 9, 0, 0, 0);
    tick("R5", 1, 1, 9, 1, 1, 9, 1, 0, 0);
    // R4: addresses already equal, left select rises late -> left busy
    tick("R4", 1, 0, 11, 0, 1, 11, 1, 0, 0);
    tick("R4", 1, 1, 11, 1, 1, 11, 1, 0, 0);
    tick("R4", 1, 1, 11, 1, 1, 11, 1, 0, 0);
    // R5: owner (right) moves away, left alone now; then right returns late
    tick("R5", 1, 1, 11, 1, 1, 12, 1, 0, 0);
    tick("R5", 1, 1, 11, 1, 1, 11, 1, 0, 0);
    tick("R5", 1, 1, 11, 1, 1, 11, 1, 0, 0);
    // R3: both move together to a new common word -> left wins again
    tick("R3", 1, 1, 13, 1, 1, 13, 1, 0, 0);
    tick("R2", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    tick("R6", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R8/R9: slave mode; collision pins ignored, external busy decides
    tick("R8", 0, 1, 5, 1, 1, 5, 1, 0, 0);
    tick("R8", 0, 1, 5, 1, 1, 5, 1, 1, 0);
    tick("R9", 0, 1, 5, 1, 1, 5, 1, 0, 1);
    tick("R9", 0, 1, 1, 1, 1, 2, 1, 1, 1);
    tick("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    tick("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // back to master, collision with writes on both sides
    tick("R7", 1, 1, 14, 1, 1, 14, 1, 0, 0);
    tick("R7", 1, 1, 14, 1, 1, 14, 1, 0, 0);
    tick("R6", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    tick("R6", 1, 0, 0, 0, 0, 0, 0, 0, 0);

    // R7: the memory written through DUT strobes matches the reference one
    for (int i = 0; i < 16; i++) begin
      vectors++;
      if (mem_dut[i] != mem_ref[i]) begin
        errors++;
        $display("FAIL R7 mem[%0d]: actual %0d expected %0d", i, mem_dut[i], mem_ref[i]);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule